// File: doc/BRIEF.md
# Delayed Branch and Annul Sequencer

This block owns the fetch address of a four-stage pipeline whose control transfers are delayed by one instruction. Each cycle the pipeline presents the decoded transfer of the instruction being resolved: its kind (none, conditional branch or call), a three-bit condition code, an annul bit, a target address and the current signed condition flags. While that transfer is resolved, the instruction right after it is already being fetched at the current fetch address. That instruction is the delay slot, and it is always fetched. The block chooses the next fetch address: the target if the transfer is taken, otherwise the next sequential word.

The block can also squash the delay slot. A squashed slot still passes through the pipeline, but as a no-op: it writes no register and no condition codes. A non-annulled transfer never squashes its slot, so the slot runs before the first target instruction. An annulled conditional branch keeps its slot only when the condition holds. An annulled branch-always or branch-never squashes the slot every time.

The controller has three states. SEQ is plain sequential flow. DELAY means the delay slot in resolve belongs to a transfer and runs normally. ANNUL means the delay slot in resolve is squashed. SEQ→DELAY and DELAY→DELAY happen on an accepted transfer that keeps its slot. SEQ→ANNUL and DELAY→ANNUL happen on an accepted transfer that squashes its slot. DELAY→SEQ happens when no transfer is presented. ANNUL→SEQ happens on every cycle, whatever the inputs are.

Top module: `dslot_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `fetch_pc` equals `RESET_PC` and `slot_kill` is 0.
- R2: When no transfer is accepted, `fetch_pc` advances by 4 on each clock. `xfer_kind` 0 means no transfer and 3 is treated the same as 0.
- R3: An accepted transfer that is taken loads `xfer_target` into `fetch_pc` on the next clock. The word fetched at the old `fetch_pc` is the delay slot, and it comes before the target.
- R4: The condition codes are evaluated against the flags `cc_nzv` = {N,Z,V} (bit 2 N, bit 1 Z, bit 0 V). The codes are: 0 never, 1 equal (Z), 2 less-or-equal (Z or N^V), 3 less (N^V), 4 always, 5 not-equal, 6 greater, 7 greater-or-equal.
- R5: Codes that differ only in bit 2 are exact complements. For any flags, exactly one branch of each such pair is taken.
- R6: `xfer_kind` 2 (call) is always taken and never squashes its slot, whatever the condition code and annul bit are.
- R7: A branch (`xfer_kind` 1) with `xfer_annul`=0 never squashes its delay slot, whether it is taken or not.
- R8: An annulled conditional branch (codes 1–3, 5–7) whose condition holds redirects without a squash. When the condition fails, the branch advances by 4 and drives `slot_kill` high for exactly the next cycle.
- R9: An annulled branch-always redirects and squashes its slot. An annulled branch-never advances by 4 and squashes its slot.
- R10: During a cycle with `slot_kill` high, the transfer inputs are ignored: `fetch_pc` advances by 4 and `slot_kill` falls on the next clock.
- R11: A transfer presented in an unsquashed delay slot (state DELAY) is accepted like any other transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_kind | input | 2 | Transfer being resolved: 0 none, 1 branch, 2 call, 3 none |
| xfer_cond | input | 3 | Branch condition code (see R4) |
| xfer_annul | input | 1 | Annul bit of the branch |
| xfer_target | input | ADDR_W | Transfer target address |
| cc_nzv | input | 3 | Condition flags {N,Z,V} |
| fetch_pc | output | ADDR_W | Address fetched in this cycle |
| slot_kill | output | 1 | Delay slot in resolve is squashed to a no-op |

## Verification
The assertions check these behaviours on every clock: the step of 4 under no transfer, the redirect for calls, that a squash lasts one cycle and ignores its inputs, that a non-annulled branch never squashes, and both annulled unconditional forms. The full condition table and its complement pairing can only be shown by the bench's scenarios. The same holds for the taken and not-taken split of annulled conditional branches and for a branch placed in a delay slot. The bench's behavioural model covers these, walking every code against all eight flag patterns and then a long random mix.

// File: rtl/dss_pkg.sv
package dss_pkg;
    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_BRANCH = 2'd1,
        XF_CALL   = 2'd2,
        XF_SPARE  = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        ST_SEQ   = 2'd0,
        ST_DELAY = 2'd1,
        ST_ANNUL = 2'd2
    } seq_state_e;

    // bit 2 inverts the sense of the test in bits 1:0
    localparam logic [2:0] CC_NEVER  = 3'd0;
    localparam logic [2:0] CC_EQ     = 3'd1;
    localparam logic [2:0] CC_LE     = 3'd2;
    localparam logic [2:0] CC_LT     = 3'd3;
    localparam logic [2:0] CC_ALWAYS = 3'd4;
    localparam logic [2:0] CC_NE     = 3'd5;
    localparam logic [2:0] CC_GT     = 3'd6;
    localparam logic [2:0] CC_GE     = 3'd7;
endpackage

// File: rtl/dss_cond_eval.sv
module dss_cond_eval
    import dss_pkg::*;
(
    input  logic [2:0] cond,
    input  logic [2:0] nzv,
    output logic       holds
);
    logic flag_n, flag_z, flag_v, less, base;

    assign flag_n = nzv[2];
    assign flag_z = nzv[1];
    assign flag_v = nzv[0];
    assign less   = flag_n ^ flag_v;

    always_comb begin
        unique case (cond[1:0])
            2'd0: base = 1'b0;
            2'd1: base = flag_z;
            2'd2: base = flag_z | less;
            2'd3: base = less;
            default: base = 1'b0;
        endcase
        holds = base ^ cond[2];
    end
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
    import dss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] kind,
    input  logic [2:0] cond,
    input  logic       annul,
    input  logic       cond_true,
    output logic       redirect,
    output logic       slot_kill
);
    seq_state_e state, state_nx;
    logic accept, is_call, squash_nx;

    assign accept  = (state != ST_ANNUL) &&
                     ((kind == XF_BRANCH) || (kind == XF_CALL));
    assign is_call = (kind == XF_CALL);
    assign squash_nx = accept && !is_call && annul &&
                       (!cond_true || (cond == CC_ALWAYS));

    always_comb begin
        state_nx = ST_SEQ;
        unique case (state)
            ST_SEQ, ST_DELAY: begin
                if (accept)
                    state_nx = squash_nx ? ST_ANNUL : ST_DELAY;
                else
                    state_nx = ST_SEQ;
            end
            ST_ANNUL: state_nx = ST_SEQ;
            default:  state_nx = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEQ;
        else        state <= state_nx;
    end

    always_comb begin
        redirect  = accept && (is_call || cond_true);
        slot_kill = (state == ST_ANNUL);
    end

    // R11: a transfer in an unsquashed slot is honoured
    assert_delay_accepts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && kind == XF_CALL) |=> (state == ST_DELAY));
endmodule

// File: rtl/dss_pc_reg.sv
module dss_pc_reg #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned STEP     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc <= RESET_PC;
        else if (redirect) pc <= target;
        else               pc <= pc + INC;
    end
endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
    import dss_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned STEP     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        xfer_kind,
    input  logic [2:0]        xfer_cond,
    input  logic              xfer_annul,
    input  logic [ADDR_W-1:0] xfer_target,
    input  logic [2:0]        cc_nzv,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              slot_kill
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    logic cond_true, redirect;

    dss_cond_eval u_eval (
        .cond  (xfer_cond),
        .nzv   (cc_nzv),
        .holds (cond_true)
    );

    dss_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (xfer_kind),
        .cond      (xfer_cond),
        .annul     (xfer_annul),
        .cond_true (cond_true),
        .redirect  (redirect),
        .slot_kill (slot_kill)
    );

    dss_pc_reg #(.ADDR_W(ADDR_W), .STEP(STEP), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .target   (xfer_target),
        .pc       (fetch_pc)
    );

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_kill && (xfer_kind == XF_NONE || xfer_kind == XF_SPARE))
        |=> (fetch_pc == $past(fetch_pc) + INC) && !slot_kill);

    assert_call_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_kill && xfer_kind == XF_CALL)
        |=> (fetch_pc == $past(xfer_target)) && !slot_kill);

    assert_kill_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_kill |=> !slot_kill && (fetch_pc == $past(fetch_pc) + INC));

    assert_plain_no_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_kill && xfer_kind == XF_BRANCH && !xfer_annul) |=> !slot_kill);

    assert_always_annul_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_kill && xfer_kind == XF_BRANCH && xfer_annul && xfer_cond == CC_ALWAYS)
        |=> slot_kill && (fetch_pc == $past(xfer_target)));

    assert_never_annul_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_kill && xfer_kind == XF_BRANCH && xfer_annul && xfer_cond == CC_NEVER)
        |=> slot_kill && (fetch_pc == $past(fetch_pc) + INC));
endmodule

// File: tb/dslot_seq_test.sv
module dslot_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  xfer_kind = 2'd0;
    logic [2:0]  xfer_cond = 3'd0;
    logic        xfer_annul = 1'b0;
    logic [31:0] xfer_target = 32'd0;
    logic [2:0]  cc_nzv = 3'd0;
    logic [31:0] fetch_pc;
    logic        slot_kill;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] m_pc;
    bit m_kill;

    always #4 clk = ~clk;

    dslot_seq uut (
        .clk(clk), .rst_n(rst_n), .xfer_kind(xfer_kind), .xfer_cond(xfer_cond),
        .xfer_annul(xfer_annul), .xfer_target(xfer_target), .cc_nzv(cc_nzv),
        .fetch_pc(fetch_pc), .slot_kill(slot_kill)
    );

    function automatic bit ref_cond(input int code, input logic [2:0] f);
        bit n = f[2], z = f[1], v = f[0];
        case (code)
            0: return 0;
            1: return z;
            2: return z || (n != v);
            3: return n != v;
            4: return 1;
            5: return !z;
            6: return !z && (n == v);
            default: return n == v;
        endcase
    endfunction

    task automatic check(input string tag);
        checks++;
        if (fetch_pc !== m_pc || slot_kill !== m_kill) begin
            errors++;
            $display("FAIL %s: pc=%h kill=%b expected pc=%h kill=%b",
                     tag, fetch_pc, slot_kill, m_pc, m_kill);
        end
    endtask

    // drive at negedge, model next state, compare at the following negedge
    task automatic step(input logic [1:0] k, input int c, input bit a,
                        input logic [31:0] t, input logic [2:0] f, input string tag);
        bit tk, kl;
        xfer_kind = k; xfer_cond = 3'(c); xfer_annul = a;
        xfer_target = t; cc_nzv = f;
        if (!m_kill && (k == 2'd1 || k == 2'd2)) begin
            tk = (k == 2'd2) || ref_cond(c, f);
            kl = (k == 2'd1) && a && (!ref_cond(c, f) || c == 4);
            m_pc = tk ? t : m_pc + 32'd4;
            m_kill = kl;
        end else begin
            m_pc = m_pc + 32'd4;
            m_kill = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb, base;
        m_pc = 32'd0; m_kill = 0;
        repeat (2) @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        m_pc = 32'd4;
        check("R1/R2 first step after reset");

        step(2'd0, 0, 0, 32'h111, 3'b000, "R2 none");
        step(2'd3, 4, 1, 32'h222, 3'b000, "R2 kind 3 as none");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R2 none");

        step(2'd2, 0, 1, 32'h400, 3'b000, "R6 call with never+annul");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R3 after target");
        step(2'd1, 4, 0, 32'h800, 3'b000, "R3 R7 always no annul");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R3 seq");
        step(2'd1, 0, 0, 32'h900, 3'b000, "R7 never no annul");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R2 seq");

        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 8; f++) begin
                step(2'd1, c, 0, 32'h1000 + 32'(c * 64 + f * 8), 3'(f), "R4 condition table");
                step(2'd0, 0, 0, 32'h0, 3'b000, "R4 return");
            end

        for (int c = 1; c < 4; c++)
            for (int f = 0; f < 8; f++) begin
                base = fetch_pc;
                step(2'd1, c, 0, 32'h7000, 3'(f), "R5 first of pair");
                pa = fetch_pc;
                step(2'd0, 0, 0, 32'h0, 3'b000, "R5 return");
                base = fetch_pc;
                step(2'd1, c + 4, 0, 32'h7000, 3'(f), "R5 second of pair");
                pb = fetch_pc;
                step(2'd0, 0, 0, 32'h0, 3'b000, "R5 return");
                checks++;
                if (((pa == 32'h7000) ? 1 : 0) + ((pb == 32'h7000) ? 1 : 0) != 1) begin
                    errors++;
                    $display("FAIL R5 code %0d flags %0d: pcs %h %h expected one redirect",
                             c, f, pa, pb);
                end
            end

        step(2'd1, 1, 1, 32'h2000, 3'b010, "R8 annul eq true");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R8 slot kept");
        step(2'd1, 1, 1, 32'h3000, 3'b000, "R8 annul eq false kills");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R8 kill one cycle");
        step(2'd1, 4, 1, 32'h4000, 3'b000, "R9 annul always");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R9 after");
        step(2'd1, 0, 1, 32'h5000, 3'b000, "R9 annul never");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R9 after");

        step(2'd1, 3, 1, 32'h6000, 3'b000, "R10 setup kill");
        step(2'd2, 0, 0, 32'h6400, 3'b000, "R10 call ignored in killed slot");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R10 after");

        step(2'd1, 4, 0, 32'h8000, 3'b000, "R11 first branch");
        step(2'd1, 4, 0, 32'h8800, 3'b000, "R11 branch in slot");
        step(2'd0, 0, 0, 32'h0, 3'b000, "R11 after");

        for (int i = 0; i < 600; i++)
            step(2'($urandom_range(0, 3)), int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 {$urandom_range(0, 32'hFFFF), 2'b00}, 3'($urandom_range(0, 7)),
                 "R8 random mix");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule